// File: doc/BRIEF.md
# Lockstep Where-Mask and Branch Reduction Unit

This unit serves an array of processing nodes that all execute one instruction stream in the same cycle. Control flow never diverges per node. A node that is outside the active conditional region still follows every instruction, but its result write is suppressed. The unit holds that per-node write mask and a small stack of nested conditional regions. Each node supplies one locally computed condition bit. The unit opens, flips and closes regions with these bits.

The unit also gives the machine-wide branch decision to the sequencer. That decision can be one of four things:
- "every active node true" (AND reduction);
- "some active node true" (OR reduction);
- a scalar condition owned by the control processor;
- an unconditional taken.

Nodes that are masked off take no part in either reduction. Stack misuse sets sticky error flags and leaves the mask untouched.

Top module: `lockstep_mask_unit`

## Requirements
- R1: After reset (rst_ni low) mask_o is all ones, depth_o is 0, ovf_o and unf_o are 0.
- R2: node_we_o[i] is instr_we_i AND mask_o[i] in the same cycle.
- R3: With op_i = 2'b01 (push) and depth below DEPTH, the next mask is the current mask AND cond_i, and depth_o rises by one.
- R4: With op_i = 2'b10 (else) and depth above 0, the next mask is the enclosing mask AND NOT the newest pushed condition. That stored condition is inverted, so a second else restores the region.
- R5: With op_i = 2'b11 (pop) and depth above 0, the mask returns to the enclosing mask and depth_o falls by one.
- R6: A push at depth DEPTH (4) sets ovf_o. The flag stays set until reset. The mask and depth stay unchanged.
- R7: An else or a pop at depth 0 sets unf_o. The flag stays set until reset. The mask stays unchanged.
- R8: With br_mode_i = 2'b00, br_taken_o is 1 when every node whose mask bit is 1 has cond_i = 1. It is 1 when no node is active.
- R9: With br_mode_i = 2'b01, br_taken_o is 1 when at least one node whose mask bit is 1 has cond_i = 1. It is 0 when no node is active.
- R10: With br_mode_i = 2'b10, br_taken_o equals ctrl_cond_i. With 2'b11, br_taken_o is 1.
- R11: op_i = 2'b00 leaves the mask and depth unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | Region operation: 00 none, 01 push, 10 else, 11 pop |
| cond_i | input | N | Local condition bit of each node |
| instr_we_i | input | 1 | Global write enable of the current instruction |
| br_mode_i | input | 2 | Branch source: 00 all, 01 any, 10 control condition, 11 always |
| ctrl_cond_i | input | 1 | Scalar condition from the control processor |
| node_we_o | output | N | Per-node gated write enable |
| mask_o | output | N | Current active-node mask |
| depth_o | output | clog2(DEPTH+1) | Number of open regions |
| br_taken_o | output | 1 | Global branch decision |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The nested-region sequence includes a push, an else, a second else and two pops. It separates a correct inversion relative to the enclosing mask from an inversion of the whole vector, and it shows that a pop restores the saved mask rather than an all-ones mask. Condition patterns are chosen so that some active nodes are true while masked nodes differ. This shows that both reductions ignore masked nodes. The all-masked case pins the empty-set results of AND and OR. A fill to full depth followed by an extra push, and pops and elses on an empty stack, show that the error flags are sticky and that the mask is not disturbed.

// File: rtl/lockstep_mask_pkg.sv
package lockstep_mask_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_PUSH = 2'b01,
    OP_ELSE = 2'b10,
    OP_POP  = 2'b11
  } where_op_e;

  typedef enum logic [1:0] {
    BR_ALL  = 2'b00,
    BR_ANY  = 2'b01,
    BR_CTRL = 2'b10,
    BR_JUMP = 2'b11
  } br_mode_e;
endpackage

// File: rtl/where_stack.sv
module where_stack
  import lockstep_mask_pkg::*;
#(
  parameter int N     = 8,
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  where_op_e     op_i,
  input  logic [N-1:0]  cond_i,
  output logic [N-1:0]  mask_o,
  output logic [DW-1:0] depth_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [N-1:0]  save_q [DEPTH];  // enclosing mask per level
  logic [N-1:0]  cnd_q  [DEPTH];  // condition of the level (inverted by else)
  logic [N-1:0]  mask_q;
  logic [DW-1:0] depth_q;
  logic          ovf_q, unf_q;
  logic          full, empty;
  logic [IW-1:0] top_idx, new_idx;

  always_comb begin
    full    = (depth_q == DW'(DEPTH));
    empty   = (depth_q == '0);
    new_idx = IW'(depth_q);
    top_idx = IW'(depth_q - DW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      for (int l = 0; l < DEPTH; l++) begin
        save_q[l] <= '1;
        cnd_q[l]  <= '1;
      end
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          if (full) begin
            ovf_q <= 1'b1;
          end else begin
            save_q[new_idx] <= mask_q;
            cnd_q[new_idx]  <= cond_i;
            mask_q          <= mask_q & cond_i;
            depth_q         <= depth_q + DW'(1);
          end
        end
        OP_ELSE: begin
          if (empty) begin
            unf_q <= 1'b1;
          end else begin
            mask_q         <= save_q[top_idx] & ~cnd_q[top_idx];
            cnd_q[top_idx] <= ~cnd_q[top_idx];
          end
        end
        OP_POP: begin
          if (empty) begin
            unf_q <= 1'b1;
          end else begin
            mask_q  <= save_q[top_idx];
            depth_q <= depth_q - DW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign mask_o  = mask_q;
  assign depth_o = depth_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
endmodule

// File: rtl/cond_reduce.sv
module cond_reduce #(
  parameter int N = 8
) (
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] mask_i,
  output logic         all_o,
  output logic         any_o
);
  logic [N-1:0] pass, hit;

  for (genvar i = 0; i < N; i++) begin : g_node
    assign pass[i] = cond_i[i] | ~mask_i[i];  // masked nodes do not veto
    assign hit[i]  = cond_i[i] &  mask_i[i];  // masked nodes do not vote
  end

  assign all_o = &pass;
  assign any_o = |hit;
endmodule

// File: rtl/lockstep_mask_unit.sv
module lockstep_mask_unit
  import lockstep_mask_pkg::*;
#(
  parameter int N     = 8,
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    op_i,
  input  logic [N-1:0]  cond_i,
  input  logic          instr_we_i,
  input  logic [1:0]    br_mode_i,
  input  logic          ctrl_cond_i,
  output logic [N-1:0]  node_we_o,
  output logic [N-1:0]  mask_o,
  output logic [DW-1:0] depth_o,
  output logic          br_taken_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [N-1:0] mask;
  logic         red_all, red_any;

  where_stack #(.N(N), .DEPTH(DEPTH)) i_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (where_op_e'(op_i)),
    .cond_i  (cond_i),
    .mask_o  (mask),
    .depth_o (depth_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  cond_reduce #(.N(N)) i_reduce (
    .cond_i (cond_i),
    .mask_i (mask),
    .all_o  (red_all),
    .any_o  (red_any)
  );

  for (genvar i = 0; i < N; i++) begin : g_we
    assign node_we_o[i] = instr_we_i & mask[i];
  end

  always_comb begin
    unique case (br_mode_e'(br_mode_i))
      BR_ALL:  br_taken_o = red_all;
      BR_ANY:  br_taken_o = red_any;
      BR_CTRL: br_taken_o = ctrl_cond_i;
      default: br_taken_o = 1'b1;
    endcase
  end

  assign mask_o = mask;
endmodule

// File: rtl/lockstep_mask_chk.sv
module lockstep_mask_chk #(
  parameter int N     = 8,
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    op_i,
  input logic [N-1:0]  cond_i,
  input logic          instr_we_i,
  input logic [1:0]    br_mode_i,
  input logic [N-1:0]  node_we_o,
  input logic [N-1:0]  mask_o,
  input logic [DW-1:0] depth_o,
  input logic          br_taken_o,
  input logic          ovf_o,
  input logic          unf_o
);
  assert_depth_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DW'(DEPTH));

  assert_we_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_we_i |-> node_we_o == '0);

  assert_we_in_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (node_we_o & ~mask_o) == '0);

  assert_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && depth_o < DW'(DEPTH)) |=>
      (mask_o == ($past(mask_o) & $past(cond_i))) && (depth_o == $past(depth_o) + DW'(1)));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && depth_o == DW'(DEPTH)) |=>
      ovf_o && $stable(mask_o) && $stable(depth_o));

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[1] && depth_o == '0) |=> unf_o && $stable(mask_o));

  assert_unf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);

  assert_all_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_mode_i == 2'b00 && mask_o == '0) |-> br_taken_o);

  assert_any_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_mode_i == 2'b01 && mask_o == '0) |-> !br_taken_o);

  assert_nop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b00 |=> $stable(mask_o) && $stable(depth_o));
endmodule

bind lockstep_mask_unit lockstep_mask_chk #(.N(N), .DEPTH(DEPTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .cond_i     (cond_i),
  .instr_we_i (instr_we_i),
  .br_mode_i  (br_mode_i),
  .node_we_o  (node_we_o),
  .mask_o     (mask_o),
  .depth_o    (depth_o),
  .br_taken_o (br_taken_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/test_lockstep_mask_unit.sv
`timescale 1ns/1ps
module test_lockstep_mask_unit;
  localparam int N = 8;
  localparam int DEPTH = 4;
  localparam int DW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] op;
  logic [N-1:0] cond;
  logic we;
  logic [1:0] mode;
  logic ctrl;
  logic [N-1:0] node_we, mask;
  logic [DW-1:0] depth;
  logic br, ovf, unf;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lockstep_mask_unit #(.N(N), .DEPTH(DEPTH)) i_lockstep_mask_unit (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .cond_i(cond), .instr_we_i(we),
    .br_mode_i(mode), .ctrl_cond_i(ctrl), .node_we_o(node_we), .mask_o(mask),
    .depth_o(depth), .br_taken_o(br), .ovf_o(ovf), .unf_o(unf)
  );

  // op, cond, we, mode, ctrl | exp node_we, exp br (before edge) | exp mask, exp depth (after edge)
  localparam logic [33:0] VECS [10] = '{
    {2'd0, 8'h0F, 1'b1, 2'd0, 1'b0, 8'hFF, 1'b0, 8'hFF, 3'd0},
    {2'd1, 8'h0F, 1'b1, 2'd1, 1'b0, 8'hFF, 1'b1, 8'h0F, 3'd1},
    {2'd0, 8'h05, 1'b1, 2'd0, 1'b0, 8'h0F, 1'b0, 8'h0F, 3'd1},
    {2'd0, 8'h0F, 1'b1, 2'd0, 1'b0, 8'h0F, 1'b1, 8'h0F, 3'd1},
    {2'd1, 8'h33, 1'b0, 2'd1, 1'b0, 8'h00, 1'b1, 8'h03, 3'd2},
    {2'd2, 8'hFF, 1'b1, 2'd2, 1'b1, 8'h03, 1'b1, 8'h0C, 3'd2},
    {2'd0, 8'h30, 1'b1, 2'd1, 1'b0, 8'h0C, 1'b0, 8'h0C, 3'd2},
    {2'd2, 8'h00, 1'b1, 2'd2, 1'b0, 8'h0C, 1'b0, 8'h03, 3'd2},
    {2'd3, 8'h00, 1'b1, 2'd3, 1'b0, 8'h03, 1'b1, 8'h0F, 3'd1},
    {2'd3, 8'h00, 1'b1, 2'd0, 1'b0, 8'h0F, 1'b0, 8'hFF, 3'd0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible at following negedge
  task automatic step(logic [1:0] o, logic [N-1:0] c, logic w, logic [1:0] m, logic k);
    op = o; cond = c; we = w; mode = m; ctrl = k;
    #1;
  endtask

  task automatic clock();
    @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(2'd0, '0, 1'b0, 2'd0, 1'b0);
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 mask", int'(mask), 'hFF);
    check("R1 depth", int'(depth), 0);
    check("R1 flags", int'({ovf, unf}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R8 R9 R10 R11 table walk
    for (int v = 0; v < 10; v++) begin
      step(VECS[v][33:32], VECS[v][31:24], VECS[v][23], VECS[v][22:21], VECS[v][20]);
      check($sformatf("R2 vec%0d we", v), int'(node_we), int'(VECS[v][19:12]));
      check($sformatf("R8/R9/R10 vec%0d br", v), int'(br), int'(VECS[v][11]));
      clock();
      check($sformatf("R3/R4/R5/R11 vec%0d mask", v), int'(mask), int'(VECS[v][10:3]));
      check($sformatf("R3/R5 vec%0d depth", v), int'(depth), int'(VECS[v][2:0]));
    end

    // R6 overflow
    step(2'd1, 8'h7F, 1'b1, 2'd0, 1'b0); clock();
    step(2'd1, 8'h3F, 1'b1, 2'd0, 1'b0); clock();
    step(2'd1, 8'h1F, 1'b1, 2'd0, 1'b0); clock();
    step(2'd1, 8'h0F, 1'b1, 2'd0, 1'b0); clock();
    check("R3 full depth", int'(depth), 4);
    check("R6 no flag yet", int'(ovf), 0);
    step(2'd1, 8'h01, 1'b1, 2'd0, 1'b0); clock();
    check("R6 ovf set", int'(ovf), 1);
    check("R6 mask kept", int'(mask), 'h0F);
    check("R6 depth kept", int'(depth), 4);
    step(2'd0, 8'h00, 1'b1, 2'd0, 1'b0); clock();
    check("R6 ovf sticky", int'(ovf), 1);
    for (int p = 0; p < 4; p++) begin
      step(2'd3, 8'h00, 1'b1, 2'd0, 1'b0); clock();
    end
    check("R5 unwound mask", int'(mask), 'hFF);

    // R7 underflow
    check("R7 no flag yet", int'(unf), 0);
    step(2'd3, 8'h00, 1'b1, 2'd0, 1'b0); clock();
    check("R7 unf on pop", int'(unf), 1);
    check("R7 mask kept pop", int'(mask), 'hFF);
    step(2'd2, 8'h00, 1'b1, 2'd0, 1'b0); clock();
    check("R7 mask kept else", int'(mask), 'hFF);
    check("R7 depth kept", int'(depth), 0);

    // R1 reset clears flags
    rst_ni = 1'b0; #1;
    check("R1 flags cleared", int'({ovf, unf}), 0);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);

    // R8 R9 empty active set
    step(2'd1, 8'h00, 1'b1, 2'd0, 1'b0); clock();
    check("R2 all masked we", int'(node_we), 0);
    step(2'd0, 8'hFF, 1'b1, 2'd0, 1'b0);
    check("R8 empty all", int'(br), 1);
    step(2'd0, 8'hFF, 1'b1, 2'd1, 1'b0);
    check("R9 empty any", int'(br), 0);
    step(2'd0, 8'h00, 1'b1, 2'd2, 1'b1);
    check("R10 ctrl", int'(br), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule